// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-on to normal operation. When it gets a start request, it first drops the "memory on" status. It then waits a long settling interval and issues a fixed list of six commands, with a guaranteed minimum spacing between them. After the last command and one more spacing interval, it raises a status bit. That bit tells the rest of the memory controller that normal traffic and periodic refresh may run.

Every command goes out as an 18-bit packed word. The word is qualified by a strobe that is high for exactly one clock. In every other cycle the word holds the idle (no-operation) code. Both delays are computed from a clock-frequency parameter and measured by one shared down-counter.

The mode register is loaded twice:

- The first load sets the DLL-reset bit.
- The second load, after the two refreshes, clears that bit and keeps the burst length and CAS latency.

The extended mode register is written before either of them. It enables the DLL and selects reduced output drive.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset the following hold: `cmd_valid_o` is 0, `cmd_word_o` is the NOP code 0x38000, and `sdram_on_o` and `busy_o` are both 0.
- R2: The command word has this layout:
  - bit 17 is RAS, bit 16 is CAS and bit 15 is WE, all active low;
  - bits 14:13 are the bank;
  - bits 12:0 are the address.
- R3: The first command appears exactly PWR_WAIT_US*CLK_MHZ cycles after the clock edge that accepts the start request, within a 2-cycle tolerance. This is 20000 cycles at the default parameters.
- R4: The commands come in this fixed order:
  1. 0x17FFF: precharge all.
  2. 0x02002: extended mode register; DLL enabled, reduced drive.
  3. 0x00163: mode register; burst 8, CL 2.5, DLL reset.
  4. 0x08000: auto-refresh.
  5. 0x08000: auto-refresh.
  6. 0x00063: mode register; DLL reset cleared.
- R5: Consecutive commands are separated by at least CMD_GAP_US*CLK_MHZ cycles, which is 200 at the defaults. The last command and the rise of `sdram_on_o` are also separated by at least that many cycles.
- R6: `cmd_valid_o` is never high for two consecutive cycles. Whenever it is low, `cmd_word_o` holds the NOP code.
- R7: When the sequence ends, `sdram_on_o` rises and `busy_o` falls. `sdram_on_o` stays high until the next start is accepted.
- R8: A start request while `busy_o` is high is ignored: the run still issues exactly six commands with unchanged spacing.
- R9: A start request after completion clears `sdram_on_o` on the accepting edge. It then replays the full sequence, including the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to (re)run the power-up sequence |
| cmd_valid_o | output | 1 | One-cycle strobe qualifying `cmd_word_o` |
| cmd_word_o | output | 18 | Packed command: RAS, CAS, WE, bank, address |
| busy_o | output | 1 | Sequence in progress |
| sdram_on_o | output | 1 | Memory initialized; normal operation and refresh enabled |

## Verification
The sequence is exercised in three ways:

- A clean run from reset checks the exact command order and the power-up delay. It also shows whether the spacing counter is reloaded for each command.
- A run with extra start pulses, both during the power-up wait and between commands, separates a sequencer that ignores them from one that restarts or skips a step.
- A second start after completion shows whether the status is cleared and whether the full wait is replayed, as opposed to re-issuing commands at once.

The NOP code is monitored in every idle cycle of every run.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    localparam int CMD_W   = 18;
    localparam int BANK_W  = 2;
    localparam int ADDR_W  = 13;
    localparam int N_STEPS = 6;
    localparam int STEP_W  = $clog2(N_STEPS + 1);

    typedef logic [CMD_W-1:0] cmd_word_t;

    // Build a packed command: active-low strobes on top, then bank, then address
    function automatic cmd_word_t mk_cmd(input logic ras_n, input logic cas_n,
                                         input logic we_n,
                                         input logic [BANK_W-1:0] bank,
                                         input logic [ADDR_W-1:0] addr);
        return {ras_n, cas_n, we_n, bank, addr};
    endfunction

    // Mode register fields
    localparam logic [ADDR_W-1:0] MR_BURST8   = 13'h003;
    localparam logic [ADDR_W-1:0] MR_CL25     = 13'h060;
    localparam logic [ADDR_W-1:0] MR_DLL_RST  = 13'h100;
    // Extended mode register fields (bit0 = 0 keeps the DLL enabled)
    localparam logic [ADDR_W-1:0] EMR_WEAK_DRV = 13'h002;

    localparam cmd_word_t CMD_NOP     = mk_cmd(1'b1, 1'b1, 1'b1, 2'b00, '0);
    localparam cmd_word_t CMD_PRE_ALL = mk_cmd(1'b0, 1'b1, 1'b0, 2'b11, '1);
    localparam cmd_word_t CMD_EMR     = mk_cmd(1'b0, 1'b0, 1'b0, 2'b01, EMR_WEAK_DRV);
    localparam cmd_word_t CMD_MR_RST  = mk_cmd(1'b0, 1'b0, 1'b0, 2'b00,
                                               MR_DLL_RST | MR_CL25 | MR_BURST8);
    localparam cmd_word_t CMD_REFRESH = mk_cmd(1'b0, 1'b0, 1'b1, 2'b00, '0);
    localparam cmd_word_t CMD_MR_RUN  = mk_cmd(1'b0, 1'b0, 1'b0, 2'b00,
                                               MR_CL25 | MR_BURST8);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PWR  = 2'd1,
        ST_GAP  = 2'd2,
        ST_ON   = 2'd3
    } seq_st_e;

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        logic              vld;
        cmd_word_t         word;
        logic              on;
    } seq_state_t;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R5: once expired and not reloaded, the counter must not wrap around
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/ddr_init_cmd_rom.sv
module ddr_init_cmd_rom
    import ddr_init_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    output cmd_word_t         word_o
);
    // R4: fixed power-up order
    always_comb begin
        case (step_i)
            STEP_W'(0): word_o = CMD_PRE_ALL;
            STEP_W'(1): word_o = CMD_EMR;
            STEP_W'(2): word_o = CMD_MR_RST;
            STEP_W'(3): word_o = CMD_REFRESH;
            STEP_W'(4): word_o = CMD_REFRESH;
            STEP_W'(5): word_o = CMD_MR_RUN;
            default:    word_o = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int PWR_WAIT_US = 100,
    parameter int CMD_GAP_US  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        cmd_valid_o,
    output logic [17:0] cmd_word_o,
    output logic        busy_o,
    output logic        sdram_on_o
);
    localparam int PWR_CYC = CLK_MHZ * PWR_WAIT_US;
    localparam int GAP_CYC = CLK_MHZ * CMD_GAP_US;
    localparam int MAX_CYC = (PWR_CYC > GAP_CYC) ? PWR_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t       s_d, s_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    cmd_word_t        rom_word;

    ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    ddr_init_cmd_rom u_rom (
        .step_i (s_q.step),
        .word_o (rom_word)
    );

    always_comb begin
        s_d      = s_q;
        s_d.vld  = 1'b0;
        s_d.word = CMD_NOP;
        t_load   = 1'b0;
        t_val    = '0;
        case (s_q.st)
            ST_IDLE, ST_ON: begin
                if (start_i) begin
                    s_d.st   = ST_PWR;
                    s_d.on   = 1'b0;
                    s_d.step = '0;
                    t_load   = 1'b1;
                    t_val    = CNT_W'(PWR_CYC - 1);
                end
            end
            ST_PWR, ST_GAP: begin
                if (t_zero) begin
                    if (s_q.step == STEP_W'(N_STEPS)) begin
                        s_d.st = ST_ON;
                        s_d.on = 1'b1;
                    end else begin
                        s_d.st   = ST_GAP;
                        s_d.vld  = 1'b1;
                        s_d.word = rom_word;
                        s_d.step = s_q.step + 1'b1;
                        t_load   = 1'b1;
                        t_val    = CNT_W'(GAP_CYC - 1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.step <= '0;
            s_q.vld  <= 1'b0;
            s_q.word <= CMD_NOP;
            s_q.on   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_valid_o = s_q.vld;
    assign cmd_word_o  = s_q.word;
    assign sdram_on_o  = s_q.on;
    assign busy_o      = (s_q.st == ST_PWR) || (s_q.st == ST_GAP);

    // Spacing monitor for assertions: cycles since the last strobe
    logic [CNT_W-1:0] since_q;
    logic             seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (cmd_valid_o) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r5_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && seen_q && busy_o && !$rose(busy_o)) |->
            (since_q >= CNT_W'(GAP_CYC - 1)));
    a_r5_gap_before_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdram_on_o) |-> (since_q >= CNT_W'(GAP_CYC - 1)));
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    a_r6_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> (cmd_word_o == CMD_NOP));
    a_r7_on_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_on_o |-> !busy_o);
    a_r9_start_clears_on: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_on_o && start_i) |=> (!sdram_on_o && busy_o));

endmodule

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
    localparam int PWR = 20000;
    localparam int GAP = 200;
    localparam logic [17:0] NOP = 18'h38000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic cmd_valid, busy, sdram_on;
    logic [17:0] cmd_word;

    ddr_init_seq u_ddr_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word),
        .busy_o(busy), .sdram_on_o(sdram_on)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0, nop_bad = 0, n_log = 0, st_cyc = 0, on_cyc = 0;
    bit finished = 0;
    logic [17:0] log_w [0:31];
    int          log_t [0:31];
    logic [17:0] exp_seq [0:5];

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                if (n_log < 32) begin
                    log_w[n_log] = cmd_word;
                    log_t[n_log] = cyc;
                end
                n_log++;
            end else if (cmd_word !== NOP) begin
                nop_bad++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1; st_cyc = cyc + 1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_on();
        for (int i = 0; i < 30000 && !sdram_on; i++) @(negedge clk);
        on_cyc = cyc;
    endtask

    // R3, R4, R5, R7: check a finished run's log
    task automatic check_run(input string tag);
        chk(n_log == 6, {tag, " R8 command count"}, n_log, 6);
        for (int i = 0; i < 6; i++)
            chk(log_w[i] == exp_seq[i], {tag, " R4 order"}, int'(log_w[i]), int'(exp_seq[i]));
        chk(log_t[0] - st_cyc >= PWR && log_t[0] - st_cyc <= PWR + 2,
            {tag, " R3 power-up wait"}, log_t[0] - st_cyc, PWR);
        for (int i = 1; i < 6; i++)
            chk(log_t[i] - log_t[i-1] >= GAP && log_t[i] - log_t[i-1] <= GAP + 2,
                {tag, " R5 spacing"}, log_t[i] - log_t[i-1], GAP);
        chk(on_cyc - log_t[5] >= GAP, {tag, " R5 gap before on"}, on_cyc - log_t[5], GAP);
        chk(sdram_on && !busy, {tag, " R7 on and idle"}, {sdram_on, busy}, 2);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(cmd_valid == 0 && cmd_word == NOP, "R1 reset command", int'(cmd_word), int'(NOP));
        chk(!sdram_on && !busy, "R1 reset status", {sdram_on, busy}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_clean_run();
        n_log = 0;
        do_start();
        chk(busy && !sdram_on, "R9 busy after start", {busy, sdram_on}, 2);
        wait_on();
        check_run("clean");
        // R2: field decode of the precharge word
        chk(log_w[0][17:15] == 3'b010 && log_w[0][10] == 1'b1, "R2 precharge fields",
            int'(log_w[0][17:15]), 2);
        chk(log_w[1][14:13] == 2'b01 && log_w[1][1:0] == 2'b10, "R2 extended mode fields",
            int'(log_w[1][14:0]), 'h2002);
        repeat (50) @(negedge clk);
        chk(sdram_on && n_log == 6, "R7 on holds", n_log, 6);
    endtask

    task automatic t_restart_busy();
        n_log = 0;
        do_start();
        chk(!sdram_on && busy, "R9 on cleared by restart", {sdram_on, busy}, 1);
        repeat (500) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;   // R8 during power-up wait
        for (int i = 0; i < 30000 && n_log < 2; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        start = 1'b1; repeat (3) @(negedge clk); start = 1'b0;  // R8 between commands
        wait_on();
        check_run("restart");
    endtask

    task automatic t_second_restart();
        n_log = 0;
        do_start();
        chk(!sdram_on, "R9 on drops again", sdram_on, 0);
        wait_on();
        check_run("again");
        chk(nop_bad == 0, "R6 NOP when idle", nop_bad, 0);
    endtask

    initial begin
        exp_seq[0] = 18'h17FFF; exp_seq[1] = 18'h02002; exp_seq[2] = 18'h00163;
        exp_seq[3] = 18'h08000; exp_seq[4] = 18'h08000; exp_seq[5] = 18'h00063;
        t_reset();
        t_clean_run();
        t_restart_busy();
        t_second_restart();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule